// File: doc/BRIEF.md
# SPI Slave with Select Resynchronization

This block is a byte-wide SPI slave. An external master supplies the serial clock. The block samples the serial clock, the active-low select and the serial input into the system clock domain through a chain of flops, and finds the serial clock edges there. No system-clock event ever moves the shifter on its own. Data leaves and enters most significant bit first.

A parallel side loads the next outgoing byte and reads the last completed one. It also sets the serial clock idle level and chooses which edge changes the output. A byte-complete flag is raised when a byte is done.

The 4-bit mode code chooses how the select pin is used:
- `4'b0100`: the pin frames every byte. Releasing it mid-byte floats the output at once and discards the partial byte, so the next byte starts aligned.
- `4'b0101`: the pin is ignored.
- Any other code leaves the slave idle.

Top module: `spi_slave_sync`

## Requirements
- R1: After the eighth sampling edge of a byte, `rx_data` holds the eight sampled `sdi` bits with the first one in bit 7, and `rx_irq` is 1.
- R2: `sdo` presents the loaded transmit byte bit 7 first, one bit per serial clock period, and the next bit is in place before the edge that samples it.
- R3: In mode 4'b0100 with `en`=1 and `sdo_off`=0, `sdo_oe` is 1 while `ss_n` is 0, and it drops to 0 in the same instant `ss_n` goes to 1, with no system clock edge needed.
- R4: In mode 4'b0100, `ss_n` high discards a partial byte and zeroes the bit count. No `rx_irq` results, and the next framed byte is received and sent whole from bit 7.
- R5: `en`=0 zeroes the bit count, discards any partial byte, and clears `rx_irq`, `wcol` and `ovf`.
- R6: In mode 4'b0101 the level of `ss_n` has no effect: `sdo_oe` is 1 and bytes move with `ss_n` held high.
- R7: `cpol` is the idle level of `sck`. With `edge_sel`=1, `sdi` is sampled on the idle-to-active edge and `sdo` changes on the active-to-idle edge. With `edge_sel`=0 the two roles swap.
- R8: `cfg_err` is 1 exactly when `en`=1, `edge_sel`=1 and `mode` is not 4'b0100.
- R9: `sdo_off`=1 holds `sdo_oe` at 0 while reception continues unchanged.
- R10: A `tx_wr` while the bit count is nonzero is ignored: the current byte and the next byte carry the earlier value. It also sets the sticky `wcol` flag.
- R11: If a byte completes while `rx_irq` is still 1, `rx_data` keeps its old value and the sticky `ovf` flag is set.
- R12: A mode code other than 4'b0100 or 4'b0101 keeps `sdo_oe` at 0 and completes no byte.
- R13: A one-cycle `rx_rd` pulse clears `rx_irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Module enable |
| mode | input | 4 | 0100 = select honoured, 0101 = select ignored, other = idle |
| cpol | input | 1 | Serial clock idle level |
| edge_sel | input | 1 | 1: output changes on the active-to-idle edge |
| sdo_off | input | 1 | Receive-only: keeps the output undriven |
| tx_wr | input | 1 | Transmit byte write strobe |
| tx_data | input | DW | Transmit byte |
| rx_rd | input | 1 | Receive byte read strobe |
| rx_data | output | DW | Last accepted received byte |
| rx_irq | output | 1 | Byte-complete flag |
| wcol | output | 1 | Sticky write-collision flag |
| ovf | output | 1 | Sticky receive overflow flag |
| cfg_err | output | 1 | Output edge select used without select framing |
| sck | input | 1 | Serial clock from the master |
| ss_n | input | 1 | Active-low slave select |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for `sdo` |

## Verification
Transfers are run for both clock polarities, both edge selects and both select-using modes, with opposite byte patterns on `sdi` and `sdo`. Pairs such as A5/3C, 81/C3 and 01/80 separate a bit-order swap from an off-by-one edge choice. A single-bit-set byte also exposes a stuck or shifted counter. Directed runs break bytes off with the select pin and with the enable, then check that the following byte comes out aligned. Further runs write during a byte, let a byte finish unread, and try an unused mode code. In each case the state that could have been disturbed is read back through the byte that follows.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;

   localparam logic [3:0] MODE_SEL_PIN  = 4'b0100;
   localparam logic [3:0] MODE_SEL_FREE = 4'b0101;

   typedef enum logic [1:0] {SEL_OFF, SEL_PIN, SEL_FREE} sel_kind_e;

   function automatic sel_kind_e decode_mode(input logic [3:0] m);
      case (m)
         MODE_SEL_PIN:  return SEL_PIN;
         MODE_SEL_FREE: return SEL_FREE;
         default:       return SEL_OFF;
      endcase
   endfunction

endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync #(
   parameter int               WIDTH   = 1,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= RST_VAL;
      else        stg[0] <= d;
   end

   for (genvar k = 1; k < STAGES; k++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[k] <= RST_VAL;
         else        stg[k] <= stg[k-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/spi_slv_edge.sv
module spi_slv_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic sck_s,
   input  logic cpol,
   output logic lead,
   output logic trail
);

   logic act, act_d;

   assign act = sck_s ^ cpol;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) act_d <= 1'b0;
      else        act_d <= act;
   end

   assign lead  = act & ~act_d;
   assign trail = ~act & act_d;

endmodule

// File: rtl/spi_slv_shift.sv
module spi_slv_shift #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          lead,
   input  logic          trail,
   input  logic          edge_sel,
   input  logic          sdi_s,
   input  logic          load,
   input  logic [DW-1:0] load_val,
   output logic          busy,
   output logic          done,
   output logic [DW-1:0] word,
   output logic          sdo_bit
);

   localparam int CW = $clog2(DW);

   logic [CW-1:0] cnt;
   logic [DW-1:0] tx_sh, rx_sh;
   logic          sample, shift, last;

   assign sample  = edge_sel ? lead  : trail;
   assign shift   = edge_sel ? trail : lead;
   assign last    = (cnt == CW'(DW-1));
   assign busy    = (cnt != '0);
   assign sdo_bit = tx_sh[DW-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         tx_sh <= '0;
         rx_sh <= '0;
         done  <= 1'b0;
         word  <= '0;
      end else begin
         done <= 1'b0;
         if (clr) begin
            cnt   <= '0;
            rx_sh <= '0;
            tx_sh <= load_val;
         end else begin
            if (load) tx_sh <= load_val;
            if (sample) begin
               rx_sh <= {rx_sh[DW-2:0], sdi_s};
               if (last) begin
                  cnt   <= '0;
                  done  <= 1'b1;
                  word  <= {rx_sh[DW-2:0], sdi_s};
                  tx_sh <= load_val;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end else if (shift && busy) begin
               tx_sh <= tx_sh << 1;
            end
         end
      end
   end

   AST_ABORT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !busy);                                               // R4
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                              // R1
   AST_EDGE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({lead, trail}));                                     // R7

endmodule

// File: rtl/spi_slave_sync.sv
module spi_slave_sync
   import spi_slv_pkg::*;
#(
   parameter int DW          = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic [3:0]    mode,
   input  logic          cpol,
   input  logic          edge_sel,
   input  logic          sdo_off,
   input  logic          tx_wr,
   input  logic [DW-1:0] tx_data,
   input  logic          rx_rd,
   output logic [DW-1:0] rx_data,
   output logic          rx_irq,
   output logic          wcol,
   output logic          ovf,
   output logic          cfg_err,
   input  logic          sck,
   input  logic          ss_n,
   input  logic          sdi,
   output logic          sdo,
   output logic          sdo_oe
);

   if (DW < 2 || SYNC_STAGES < 2) begin : g_bad_param
      $error("spi_slave_sync: DW and SYNC_STAGES must each be at least 2");
   end

   sel_kind_e     sel;
   logic          slave_on, ss_ctl, clr, load, busy, done, sdo_bit;
   logic          sck_s, ss_s, sdi_s, lead, trail;
   logic [DW-1:0] tx_buf, load_val, word;

   spi_slv_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({sck, ss_n, sdi}), .q({sck_s, ss_s, sdi_s})
   );

   spi_slv_edge u_edge (
      .clk(clk), .rst_n(rst_n), .sck_s(sck_s), .cpol(cpol),
      .lead(lead), .trail(trail)
   );

   assign sel      = decode_mode(mode);
   assign slave_on = en && (sel != SEL_OFF);
   assign ss_ctl   = (sel == SEL_PIN);
   assign clr      = !slave_on || (ss_ctl && ss_s);
   assign load     = tx_wr && !busy;
   assign load_val = load ? tx_data : tx_buf;

   spi_slv_shift #(.DW(DW)) u_shift (
      .clk(clk), .rst_n(rst_n), .clr(clr), .lead(lead), .trail(trail),
      .edge_sel(edge_sel), .sdi_s(sdi_s), .load(load), .load_val(load_val),
      .busy(busy), .done(done), .word(word), .sdo_bit(sdo_bit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_buf  <= '0;
         rx_data <= '0;
         rx_irq  <= 1'b0;
         wcol    <= 1'b0;
         ovf     <= 1'b0;
      end else begin
         if (load) tx_buf <= tx_data;
         if (!en) begin
            rx_irq <= 1'b0;
            wcol   <= 1'b0;
            ovf    <= 1'b0;
         end else begin
            if (tx_wr && busy) wcol <= 1'b1;
            if (done) begin
               if (rx_irq && !rx_rd) begin
                  ovf <= 1'b1;
               end else begin
                  rx_data <= word;
                  rx_irq  <= 1'b1;
               end
            end else if (rx_rd) begin
               rx_irq <= 1'b0;
            end
         end
      end
   end

   // Output enable follows the raw select pin so release floats sdo at once.
   assign sdo_oe  = slave_on && !sdo_off && (ss_ctl ? !ss_n : 1'b1);
   assign sdo     = sdo_bit;
   assign cfg_err = en && edge_sel && (mode != MODE_SEL_PIN);

   AST_OE_SS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (ss_ctl && ss_n) |-> !sdo_oe);                                 // R3
   AST_WCOL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (en && tx_wr && busy) |=> (wcol && $stable(tx_buf)));          // R10
   AST_OVF_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (en && done && rx_irq && !rx_rd) |=> (ovf && $stable(rx_data))); // R11
   AST_DONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (en && done) |=> rx_irq);                                      // R1
   AST_DIS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!rx_irq && !wcol && !ovf && !busy));                  // R5
   AST_CFG_EN: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> !cfg_err);                                             // R8

endmodule

// File: tb/sim_spi_slave_sync.sv
`timescale 1ns/1ps
module sim_spi_slave_sync;

   localparam int H = 80;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic [3:0] mode = 4'b0000;
   logic       cpol_r = 1'b0, edge_r = 1'b0, sdo_off = 1'b0;
   logic       tx_wr = 1'b0, rx_rd = 1'b0;
   logic [7:0] tx_data = 8'h00;
   logic [7:0] rx_data;
   logic       rx_irq, wcol, ovf, cfg_err;
   logic       sck = 1'b0, ss_n = 1'b1, sdi = 1'b0;
   logic       sdo, sdo_oe;

   int         n_chk = 0, n_fail = 0;
   logic [7:0] miso_g;
   logic       oe_ok_g;
   bit         finished = 0;

   always #5 clk = ~clk;

   spi_slave_sync u0 (
      .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .cpol(cpol_r),
      .edge_sel(edge_r), .sdo_off(sdo_off), .tx_wr(tx_wr), .tx_data(tx_data),
      .rx_rd(rx_rd), .rx_data(rx_data), .rx_irq(rx_irq), .wcol(wcol),
      .ovf(ovf), .cfg_err(cfg_err), .sck(sck), .ss_n(ss_n), .sdi(sdi),
      .sdo(sdo), .sdo_oe(sdo_oe)
   );

   // mode[21:18] cpol[17] edge[16] tx[15:8] rx_in[7:0]
   localparam logic [21:0] VEC [5] = '{
      {4'b0100, 1'b0, 1'b1, 8'hA5, 8'h3C},
      {4'b0100, 1'b1, 1'b1, 8'h81, 8'hC3},
      {4'b0100, 1'b0, 1'b0, 8'h5A, 8'h96},
      {4'b0101, 1'b1, 1'b0, 8'hF0, 8'h0F},
      {4'b0101, 1'b0, 1'b0, 8'h01, 8'h80}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cfg(input logic [3:0] m, input logic cp, input logic ed);
      @(negedge clk);
      en = 1'b0; ss_n = 1'b1;
      mode = m; cpol_r = cp; edge_r = ed; sck = cp;
      repeat (6) @(negedge clk);
      en = 1'b1;
      @(negedge clk);
   endtask

   task automatic wtx(input logic [7:0] v);
      @(negedge clk); tx_wr = 1'b1; tx_data = v;
      @(negedge clk); tx_wr = 1'b0;
   endtask

   task automatic rdrx();
      @(negedge clk); rx_rd = 1'b1;
      @(negedge clk); rx_rd = 1'b0;
   endtask

   // Clock bits hi..lo of mosi; record sdo into miso_g.
   task automatic bits(input logic [7:0] mosi, input int hi, input int lo);
      for (int i = hi; i >= lo; i--) begin
         if (edge_r) begin
            sdi = mosi[i]; #(H);
            miso_g[i] = sdo; if (!sdo_oe) oe_ok_g = 1'b0;
            sck = ~cpol_r; #(H);
            sck = cpol_r;
         end else begin
            sck = ~cpol_r; #(H);
            sdi = mosi[i];
            miso_g[i] = sdo; if (!sdo_oe) oe_ok_g = 1'b0;
            #(H);
            sck = cpol_r; #(H);
         end
      end
      #(H);
   endtask

   task automatic xfer(input logic [7:0] mosi);
      miso_g = 8'h00; oe_ok_g = 1'b1;
      bits(mosi, 7, 0);
      #(200);
   endtask

   initial begin
      #(1_000_000);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      // Reset state
      check("R5 reset sdo_oe", sdo_oe, 0);
      check("R1 reset rx_irq", rx_irq, 0);
      check("R10 reset wcol", wcol, 0);
      check("R11 reset ovf", ovf, 0);
      check("R1 reset rx_data", rx_data, 0);

      // Table of transfers across modes, polarities and edge selects
      for (int v = 0; v < 5; v++) begin
         cfg(VEC[v][21:18], VEC[v][17], VEC[v][16]);
         wtx(VEC[v][15:8]);
         if (VEC[v][21:18] == 4'b0100) begin ss_n = 1'b0; #(H); end
         xfer(VEC[v][7:0]);
         check($sformatf("R1 R7 vec%0d rx_data", v), rx_data, VEC[v][7:0]);
         check($sformatf("R1 vec%0d rx_irq", v), rx_irq, 1);
         check($sformatf("R2 R7 vec%0d sdo bits", v), miso_g, VEC[v][15:8]);
         check($sformatf("R3 R6 vec%0d sdo_oe during byte", v), oe_ok_g, 1);
         ss_n = 1'b1;
         rdrx();
         check($sformatf("R13 vec%0d rx_irq cleared", v), rx_irq, 0);
      end

      // R3 and R4: select release mid-byte
      cfg(4'b0100, 1'b0, 1'b0);
      wtx(8'hC5);
      ss_n = 1'b0; #(H);
      check("R3 oe with ss low", sdo_oe, 1);
      oe_ok_g = 1'b1;
      bits(8'hFF, 7, 5);
      ss_n = 1'b1; #1;
      check("R3 oe drops at once", sdo_oe, 0);
      #(400);
      check("R4 no irq after abort", rx_irq, 0);
      ss_n = 1'b0; #(H);
      xfer(8'h6B);
      check("R4 aligned rx after abort", rx_data, 8'h6B);
      check("R4 aligned tx after abort", miso_g, 8'hC5);
      ss_n = 1'b1;
      rdrx();

      // R6: select ignored in mode 0101
      cfg(4'b0101, 1'b0, 1'b0);
      wtx(8'h3E);
      check("R6 oe with ss high", sdo_oe, 1);
      // R10: write collision mid-byte
      miso_g = 8'h00; oe_ok_g = 1'b1;
      bits(8'h9C, 7, 4);
      wtx(8'h99);
      bits(8'h9C, 3, 0);
      #(200);
      check("R10 wcol set", wcol, 1);
      check("R10 current byte intact", miso_g, 8'h3E);
      check("R6 rx with ss high", rx_data, 8'h9C);
      // R11: next byte completes unread
      xfer(8'h77);
      check("R10 next byte keeps old tx", miso_g, 8'h3E);
      check("R11 rx_data kept", rx_data, 8'h9C);
      check("R11 ovf set", ovf, 1);

      // R5: disable clears flags and partial byte
      @(negedge clk); en = 1'b0;
      repeat (3) @(negedge clk);
      check("R5 irq cleared", rx_irq, 0);
      check("R5 wcol cleared", wcol, 0);
      check("R5 ovf cleared", ovf, 0);
      en = 1'b1; @(negedge clk);
      bits(8'h00, 7, 5);
      @(negedge clk); en = 1'b0;
      repeat (3) @(negedge clk); en = 1'b1;
      repeat (3) @(negedge clk);
      xfer(8'hD2);
      check("R5 aligned rx after disable", rx_data, 8'hD2);
      rdrx();

      // R9: receive-only
      cfg(4'b0100, 1'b0, 1'b0);
      sdo_off = 1'b1;
      ss_n = 1'b0; #(H);
      check("R9 oe off", sdo_oe, 0);
      xfer(8'h4E);
      check("R9 rx continues", rx_data, 8'h4E);
      ss_n = 1'b1; sdo_off = 1'b0;
      rdrx();

      // R8: configuration error
      @(negedge clk); mode = 4'b0101; edge_r = 1'b1; #1;
      check("R8 edge_sel without select", cfg_err, 1);
      mode = 4'b0100; #1;
      check("R8 edge_sel with select", cfg_err, 0);
      mode = 4'b0101; en = 1'b0; #1;
      check("R8 disabled", cfg_err, 0);

      // R12: unused mode code
      cfg(4'b0000, 1'b0, 1'b0);
      ss_n = 1'b0; #(H);
      check("R12 oe off", sdo_oe, 0);
      xfer(8'hFF);
      check("R12 no byte", rx_irq, 0);
      ss_n = 1'b1;

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule